// File: doc/BRIEF.md
# Privilege and Segment Address Checker

This block sits in front of a translation lookaside buffer and judges each virtual access before any lookup happens. From the processor status word it works out the current privilege level. It splits the virtual address space into three kinds of region: a directly mapped cached window, a directly mapped uncached window, and everything else, which must go through the TLB. For the two direct windows it produces the physical address straight away.

It also raises an address error for misaligned accesses and for privilege violations. When an error is raised, the faulting address is reported and a flag tells a store error apart from a load or fetch error. Independently of the region, it marks a request as uncacheable from two address bits.

All outputs are registered once. The result for the inputs present at one rising clock edge appears after that edge and holds for one cycle.

Top module: `seg_priv_checker`

## Requirements
- R1: The privilege output is kernel (code 0) whenever any of status bits 28, 2 or 1 is set, whatever the mode field holds. It is also kernel when the two-bit mode field at status bits 4:3 is 00.
- R2: When status bits 28, 2 and 1 are all clear, mode field 01 gives supervisor (code 1), 10 gives user (code 2), and 11 gives the reserved code 3.
- R3: Virtual addresses with bits 31:29 = 100 or 101 are direct and keep the use-TLB output low. Every other address raises use-TLB, unless an address error is raised for that access.
- R4: For a direct address the physical address output is the virtual address with bits 31:29 cleared, and this holds even when an error is raised. For a TLB-bound address the output is zero.
- R5: The uncacheable output is high exactly when virtual address bits 31 and 29 are both set, in any region.
- R6: An access whose size in bytes minus one has any bit in common with the virtual address is misaligned. A misaligned access raises the address error in every region.
- R7: An access to the cached direct region (bits 31:29 = 100) from any level other than kernel raises the address error, and this includes the reserved code. The uncached direct region has no privilege check.
- R8: The access type is 0 for fetch, 1 for load, 2 for store, and 3 is treated as a load. The store-error output is high only when the address error is high and the type is 2.
- R9: The bad-address output carries the virtual address while the address error is high and is zero otherwise.
- R10: Results appear one clock after the inputs are sampled. While reset is active, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| status_i | input | 32 | Processor status word |
| vaddr_i | input | 32 | Virtual address of the access |
| size_i | input | 4 | Access size in bytes (1, 2, 4 or 8) |
| acc_type_i | input | 2 | 0 fetch, 1 load, 2 store, 3 treated as load |
| mode_o | output | 2 | Privilege code: 0 kernel, 1 supervisor, 2 user, 3 reserved |
| use_tlb_o | output | 1 | Access must be translated by the TLB |
| paddr_o | output | 32 | Physical address for direct regions, zero otherwise |
| uncache_o | output | 1 | Request is uncacheable |
| aerr_o | output | 1 | Address error |
| aerr_store_o | output | 1 | Address error on a store |
| badvaddr_o | output | 32 | Faulting virtual address while aerr_o is high |

## Verification
The bench builds the block with its defaults: 32-bit status and address, and a 4-bit size. With these values all eight 512 MB regions selected by the top three address bits can be reached by drawing those bits uniformly. Sizes of 1 to 8 bytes bring alignment faults on the low three address bits within reach. Status words are drawn with the override bits mostly cleared, so that all four mode-field codes, and the reserved one in particular, meet the cached direct region.

// File: rtl/seg_chk_pkg.sv
package seg_chk_pkg;

  typedef enum logic [1:0] {
    PM_KERNEL = 2'd0,
    PM_SUPER  = 2'd1,
    PM_USER   = 2'd2,
    PM_RSVD   = 2'd3
  } priv_mode_e;

  typedef enum logic [1:0] {
    SEG_MAPPED   = 2'd0,
    SEG_DIRECT_C = 2'd1,
    SEG_DIRECT_U = 2'd2
  } seg_kind_e;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_kind_e;

endpackage

// File: rtl/priv_mode_decode.sv
module priv_mode_decode
  import seg_chk_pkg::*;
#(
  parameter int                STAT_W    = 32,
  parameter logic [STAT_W-1:0] OVR_MASK  = STAT_W'(32'h1000_0006),
  parameter int                FIELD_LSB = 3
) (
  input  logic [STAT_W-1:0] status_i,
  output priv_mode_e        mode_o,
  output logic              ovr_o
);

  // Any override bit forces kernel; otherwise the two-bit field decides.
  function automatic priv_mode_e f_mode(input logic [STAT_W-1:0] s);
    logic [1:0] fld;
    fld = s[FIELD_LSB +: 2];
    if ((s & OVR_MASK) != '0 || fld == 2'b00) return PM_KERNEL;
    return priv_mode_e'(fld);
  endfunction

  assign ovr_o  = (status_i & OVR_MASK) != '0;
  assign mode_o = f_mode(status_i);

endmodule

// File: rtl/addr_segment_classify.sv
module addr_segment_classify
  import seg_chk_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 4
) (
  input  logic [ADDR_W-1:0] vaddr_i,
  input  logic [SIZE_W-1:0] size_i,
  output seg_kind_e         seg_o,
  output logic [ADDR_W-1:0] direct_pa_o,
  output logic              uncache_o,
  output logic              misalign_o
);

  localparam int TOP_W = 3;
  localparam int OFS_W = ADDR_W - TOP_W;

  function automatic seg_kind_e f_seg(input logic [TOP_W-1:0] top);
    case (top)
      3'b100:  return SEG_DIRECT_C;
      3'b101:  return SEG_DIRECT_U;
      default: return SEG_MAPPED;
    endcase
  endfunction

  function automatic logic f_misalign(input logic [ADDR_W-1:0] va,
                                      input logic [SIZE_W-1:0] sz);
    logic [SIZE_W-1:0] m;
    m = sz - SIZE_W'(1);
    return (va & {{(ADDR_W-SIZE_W){1'b0}}, m}) != '0;
  endfunction

  assign seg_o       = f_seg(vaddr_i[ADDR_W-1 -: TOP_W]);
  assign direct_pa_o = {{TOP_W{1'b0}}, vaddr_i[OFS_W-1:0]};
  assign uncache_o   = vaddr_i[ADDR_W-1] & vaddr_i[ADDR_W-3];
  assign misalign_o  = f_misalign(vaddr_i, size_i);

endmodule

// File: rtl/seg_priv_checker.sv
module seg_priv_checker
  import seg_chk_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int STAT_W = 32,
  parameter int SIZE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] status_i,
  input  logic [ADDR_W-1:0] vaddr_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [1:0]        acc_type_i,
  output logic [1:0]        mode_o,
  output logic              use_tlb_o,
  output logic [ADDR_W-1:0] paddr_o,
  output logic              uncache_o,
  output logic              aerr_o,
  output logic              aerr_store_o,
  output logic [ADDR_W-1:0] badvaddr_o
);

  priv_mode_e        mode_w;
  logic              ovr_hit;
  seg_kind_e         seg_w;
  logic [ADDR_W-1:0] direct_pa;
  logic              unc_w;
  logic              misalign_w;

  priv_mode_decode #(.STAT_W(STAT_W)) u_mode (
    .status_i (status_i),
    .mode_o   (mode_w),
    .ovr_o    (ovr_hit)
  );

  addr_segment_classify #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_seg (
    .vaddr_i     (vaddr_i),
    .size_i      (size_i),
    .seg_o       (seg_w),
    .direct_pa_o (direct_pa),
    .uncache_o   (unc_w),
    .misalign_o  (misalign_w)
  );

  // Named internal events
  logic priv_fault;
  logic aerr_d;
  logic use_tlb_d;
  logic store_d;
  logic [ADDR_W-1:0] paddr_d;

  assign priv_fault = (seg_w == SEG_DIRECT_C) && (mode_w != PM_KERNEL);
  assign aerr_d     = misalign_w | priv_fault;
  assign use_tlb_d  = (seg_w == SEG_MAPPED) && !aerr_d;
  assign store_d    = aerr_d && (acc_kind_e'(acc_type_i) == ACC_STORE);
  assign paddr_d    = (seg_w == SEG_MAPPED) ? '0 : direct_pa;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_o       <= '0;
      use_tlb_o    <= 1'b0;
      paddr_o      <= '0;
      uncache_o    <= 1'b0;
      aerr_o       <= 1'b0;
      aerr_store_o <= 1'b0;
      badvaddr_o   <= '0;
    end else begin
      mode_o       <= mode_w;
      use_tlb_o    <= use_tlb_d;
      paddr_o      <= paddr_d;
      uncache_o    <= unc_w;
      aerr_o       <= aerr_d;
      aerr_store_o <= store_d;
      badvaddr_o   <= aerr_d ? vaddr_i : '0;
    end
  end

  // Assertions
  p_ovr_kernel_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_hit |=> (mode_o == 2'd0));

  p_tlb_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    use_tlb_o |-> !aerr_o);

  p_priv_fault_r7: assert property (@(posedge clk) disable iff (!rst_n)
    priv_fault |=> aerr_o);

  p_store_sub_r8: assert property (@(posedge clk) disable iff (!rst_n)
    aerr_store_o |-> aerr_o);

  p_bad_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    aerr_o |-> (badvaddr_o == $past(vaddr_i)));

endmodule

// File: tb/seg_priv_checker_tb.sv
`timescale 1ns/1ps
module seg_priv_checker_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] status_i = '0;
  logic [31:0] vaddr_i = '0;
  logic [3:0]  size_i = 4'd1;
  logic [1:0]  acc_type_i = '0;
  logic [1:0]  mode_o;
  logic        use_tlb_o;
  logic [31:0] paddr_o;
  logic        uncache_o;
  logic        aerr_o;
  logic        aerr_store_o;
  logic [31:0] badvaddr_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  seg_priv_checker dut_i (
    .clk(clk), .rst_n(rst_n), .status_i(status_i), .vaddr_i(vaddr_i),
    .size_i(size_i), .acc_type_i(acc_type_i), .mode_o(mode_o),
    .use_tlb_o(use_tlb_o), .paddr_o(paddr_o), .uncache_o(uncache_o),
    .aerr_o(aerr_o), .aerr_store_o(aerr_store_o), .badvaddr_o(badvaddr_o)
  );

  // Reference model written from the requirements
  function automatic logic [1:0] ref_mode(input logic [31:0] s);
    if (s[28] || s[2] || s[1]) return 2'd0;
    return s[4:3];
  endfunction

  function automatic logic ref_direct(input logic [31:0] va);
    return (va >> 29) == 32'd4 || (va >> 29) == 32'd5;
  endfunction

  function automatic logic ref_aerr(input logic [31:0] s, input logic [31:0] va,
                                    input logic [3:0] sz);
    logic mis, priv;
    mis  = (va % {28'd0, sz}) != 0;
    priv = ((va >> 29) == 32'd4) && (ref_mode(s) != 2'd0);
    return mis || priv;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_vec(input logic [31:0] s, input logic [31:0] va,
                         input logic [3:0] sz, input logic [1:0] acc);
    logic e;
    @(negedge clk);
    status_i = s; vaddr_i = va; size_i = sz; acc_type_i = acc;
    @(posedge clk);
    @(negedge clk);
    e = ref_aerr(s, va, sz);
    chk("R1/R2 mode",   {30'd0, mode_o}, {30'd0, ref_mode(s)});
    chk("R3 use_tlb",   {31'd0, use_tlb_o}, {31'd0, !ref_direct(va) && !e});
    chk("R4 paddr",     paddr_o, ref_direct(va) ? (va & 32'h1FFF_FFFF) : 32'd0);
    chk("R5 uncache",   {31'd0, uncache_o}, {31'd0, va[31] && va[29]});
    chk("R6/R7 aerr",   {31'd0, aerr_o}, {31'd0, e});
    chk("R8 store_err", {31'd0, aerr_store_o}, {31'd0, e && acc == 2'd2});
    chk("R9 badvaddr",  badvaddr_o, e ? va : 32'd0);
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    // R10: reset state
    status_i = 32'h0000_0010; vaddr_i = 32'h8000_0003; size_i = 4'd4; acc_type_i = 2'd2;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 reset mode",  {30'd0, mode_o}, 32'd0);
    chk("R10 reset aerr",  {31'd0, aerr_o}, 32'd0);
    chk("R10 reset paddr", paddr_o, 32'd0);
    chk("R10 reset bad",   badvaddr_o, 32'd0);
    rst_n = 1'b1;

    // R10: one-cycle latency, output still shows the old vector before the edge
    @(negedge clk);
    status_i = 32'h0; vaddr_i = 32'h9000_0000; size_i = 4'd1; acc_type_i = 2'd1;
    @(posedge clk); @(negedge clk);
    status_i = 32'h10; vaddr_i = 32'h8000_0000;
    #1;
    chk("R10 latency hold", {31'd0, aerr_o}, 32'd0);
    @(posedge clk); @(negedge clk);
    chk("R10 latency update", {31'd0, aerr_o}, 32'd1);

    // R1: override bits force kernel
    run_vec(32'h1000_0010, 32'h8000_1000, 4'd4, 2'd1);
    run_vec(32'h0000_0012, 32'h8000_1000, 4'd4, 2'd1);
    run_vec(32'h0000_001C, 32'h8000_1000, 4'd4, 2'd0);
    run_vec(32'h0000_0000, 32'h8000_1000, 4'd4, 2'd0);
    // R2: field codes
    run_vec(32'h0000_0008, 32'h0040_0000, 4'd4, 2'd0);
    run_vec(32'h0000_0010, 32'h0040_0000, 4'd4, 2'd0);
    run_vec(32'h0000_0018, 32'h0040_0000, 4'd4, 2'd0);
    // R7: cached direct region from user / reserved / supervisor, store
    run_vec(32'h0000_0010, 32'h8000_1000, 4'd4, 2'd2);
    run_vec(32'h0000_0018, 32'h9FFF_FFF0, 4'd8, 2'd1);
    run_vec(32'h0000_0008, 32'h8000_0000, 4'd1, 2'd0);
    // R7: uncached direct region from user has no privilege check (R4, R5)
    run_vec(32'h0000_0010, 32'hA000_1000, 4'd4, 2'd1);
    run_vec(32'h0000_0010, 32'hBFFF_FFFC, 4'd4, 2'd2);
    // R6: misaligned in each region kind
    run_vec(32'h0000_0000, 32'h8000_0002, 4'd4, 2'd1);
    run_vec(32'h0000_0010, 32'h0040_0001, 4'd2, 2'd2);
    run_vec(32'h0000_0000, 32'hB000_0004, 4'd8, 2'd3);
    // R5: uncacheable in a TLB-bound region; R3: 0xC region is mapped
    run_vec(32'h0000_0010, 32'hE000_0000, 4'd4, 2'd1);
    run_vec(32'h0000_0010, 32'hC000_0000, 4'd4, 2'd1);

    // Constrained random
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] s, va;
      logic [3:0]  sz;
      logic [1:0]  acc;
      s = $urandom();
      if (($urandom() % 4) != 0) s = s & ~32'h1000_0006;
      va = $urandom();
      if (($urandom() % 2) == 0) va = va & ~32'h7;
      sz = 4'd1 << ($urandom() % 4);
      acc = 2'($urandom());
      run_vec(s, va, sz, acc);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule